// File: doc/BRIEF.md
# Page-Buffered Memory Write and Read Pointer Engine

This block sits behind a two-wire serial slave front end and owns all the addressing of a 256-byte, byte-wide memory. The front end decodes the bus and hands over byte-level events: a write-select (device select with the write direction acknowledged), each received byte, a stop, and a request for the next byte to transmit. In a write, the first byte after the write-select is a word address. Every byte that follows is data and is collected in a 16-entry page buffer.

The memory is divided into 16-byte pages. Data bytes walk through the page using only the low four address bits, so a long burst wraps inside its page and overwrites earlier entries. Nothing reaches the memory before the stop. At the stop, the received entries, and only those, are copied into the storage as one self-timed programming cycle. During that cycle a busy flag is raised, which the front end uses to withhold acknowledges. While busy is high, every input of the block is ignored.

Reads come from one auto-incrementing pointer. This pointer is shared by current-address reads, random reads (a dummy write of the address, then a read) and sequential reads. During reads it wraps across the whole 256-byte space. The cell technology is modelled as a synchronous RAM, and the length of the programming cycle is a parameter counted in system clocks.

Top module: `pw_page_engine`

## Requirements
- R1: After reset, busy_o and rd_valid_o are low.
- R2: After sel_wr_i, the first byte_vld_i byte loads the 8-bit pointer. A following read request returns the memory byte at that address.
- R3: Each data byte goes to the pointer's page position, then only pointer bits [3:0] increment, so offset 0xF wraps to 0x0 and bits [7:4] never change during a write.
- R4: When more than 16 data bytes arrive before stop, a later byte replaces the earlier byte at the same wrapped position, and only the latest value is committed.
- R5: Memory changes only through a commit started by stop. A commit writes exactly the positions received since the last sel_wr_i and leaves the rest of the page untouched. A new sel_wr_i discards uncommitted bytes.
- R6: A stop with at least one buffered data byte raises busy_o on the next cycle for exactly WR_CYCLES cycles. A stop with no data bytes leaves busy_o low.
- R7: While busy_o is high, sel_wr_i, byte_vld_i, stop_i and rd_req_i are ignored. No read data is produced, and the pointer, the buffer, the memory and the busy length are unaffected.
- R8: A read request accepted in one cycle gives rd_valid_o with the byte at the pointer in the next cycle. The pointer then advances by one over the full space, from 0xFF to 0x00.
- R9: After a write, a read without a new address returns the byte after the last data byte within its page (the pointer left by R3).
- R10: Same-cycle inputs are prioritised as sel_wr_i, then stop_i, then rd_req_i, then byte_vld_i. Bytes arriving with no open write-select are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_wr_i | input | 1 | Pulse: write-direction device select acknowledged |
| byte_vld_i | input | 1 | Pulse: a received byte is on byte_i |
| byte_i | input | DATA_W | Received byte (word address or data) |
| stop_i | input | 1 | Pulse: stop condition seen |
| rd_req_i | input | 1 | Pulse: front end needs the next byte to transmit |
| rd_valid_o | output | 1 | Read byte on rd_data_o is valid |
| rd_data_o | output | DATA_W | Byte read from the memory |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The bench builds the block with WR_CYCLES set to 24. This keeps each programming cycle short, so the bench can run many commits and can measure every busy window exactly. It is still longer than the 16-cycle copy phase, so the copy and the idle tail both occur. The short window leaves room to inject a full write transaction and read requests inside one busy period and then show that nothing changed. Address and page geometry keep their defaults, so the page wrap at offset 0xF and the full-space wrap from 0xFF to 0x00 are both reached.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              any_o
);
  localparam int ENTRIES = 1 << OFS_W;

  logic [ENTRIES-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]  slot_q [ENTRIES];

  always_comb begin
    mask_d = mask_q;
    if (clr_i) begin
      mask_d = '0;
    end else if (wr_en_i) begin
      mask_d[wr_ofs_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && !clr_i && (wr_ofs_i == OFS_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ofs_i];
  assign rd_hit_o  = mask_q[rd_ofs_i];
  assign any_o     = |mask_q;
endmodule

// File: rtl/pw_cell_array.sv
module pw_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) cell_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= cell_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pw_wr_timer.sv
module pw_wr_timer #(
  parameter int WR_CYCLES = 5000,
  parameter int OFS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             copy_en_o,
  output logic [OFS_W-1:0] copy_idx_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W:0]   COPY_N = (CNT_W + 1)'(1 << OFS_W);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        done_o = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o     = busy_q;
  assign copy_en_o  = busy_q && ({1'b0, cnt_q} < COPY_N);
  assign copy_idx_o = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/pw_page_engine.sv
module pw_page_engine
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int PG_W = ADDR_W - OFS_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  wr_phase_e         ph_q, ph_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [OFS_W-1:0]  ofs_inc;
  logic [ADDR_W-1:0] ptr_inc;
  logic              buf_wr, buf_clr, start_commit, rd_fire;
  logic              busy, copy_en, commit_done, buf_any, buf_hit;
  logic [OFS_W-1:0]  copy_idx;
  logic [DATA_W-1:0] buf_data;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic              rd_valid_q;

  assign ofs_inc = ptr_q[OFS_W-1:0] + OFS_W'(1);
  assign ptr_inc = ptr_q + ADDR_W'(1);

  always_comb begin
    ph_d         = ph_q;
    ptr_d        = ptr_q;
    buf_wr       = 1'b0;
    buf_clr      = commit_done;
    start_commit = 1'b0;
    rd_fire      = 1'b0;
    if (!busy) begin
      if (sel_wr_i) begin
        ph_d    = PH_ADDR;
        buf_clr = 1'b1;
      end else if (stop_i) begin
        ph_d         = PH_IDLE;
        start_commit = buf_any;
      end else if (rd_req_i) begin
        ph_d    = PH_IDLE;
        rd_fire = 1'b1;
        ptr_d   = ptr_inc;
      end else if (byte_vld_i) begin
        case (ph_q)
          PH_ADDR: begin
            ptr_d = byte_i[ADDR_W-1:0];
            ph_d  = PH_DATA;
          end
          PH_DATA: begin
            buf_wr = 1'b1;
            ptr_d  = {ptr_q[ADDR_W-1:OFS_W], ofs_inc};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ph_q       <= PH_IDLE;
      ptr_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      ptr_q      <= ptr_d;
      rd_valid_q <= rd_fire;
    end
  end

  pw_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (buf_clr),
    .wr_en_i   (buf_wr),
    .wr_ofs_i  (ptr_q[OFS_W-1:0]),
    .wr_data_i (byte_i),
    .rd_ofs_i  (copy_idx),
    .rd_data_o (buf_data),
    .rd_hit_o  (buf_hit),
    .any_o     (buf_any)
  );

  pw_wr_timer #(.WR_CYCLES(WR_CYCLES), .OFS_W(OFS_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_commit),
    .busy_o     (busy),
    .copy_en_o  (copy_en),
    .copy_idx_o (copy_idx),
    .done_o     (commit_done)
  );

  assign ram_we   = copy_en && buf_hit;
  assign ram_addr = busy ? {ptr_q[ADDR_W-1:OFS_W], copy_idx} : ptr_q;

  pw_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .re_i    (rd_fire),
    .addr_i  (ram_addr),
    .wdata_i (buf_data),
    .rdata_o (rd_data_o)
  );

  assign rd_valid_o = rd_valid_q;
  assign busy_o     = busy;

  logic unused_pg;
  assign unused_pg = ^PG_W;
endmodule

// File: rtl/pw_page_engine_chk.sv
module pw_page_engine_chk #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic sel_wr_i,
  input logic stop_i,
  input logic rd_req_i,
  input logic rd_valid_o,
  input logic busy_o,
  input logic ram_we,
  input logic buf_any
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!busy_o && !rd_valid_o));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i && !sel_wr_i && buf_any));

  // R6
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !sel_wr_i && !busy_o && !buf_any) |=> !busy_o);

  // R6
  full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !sel_wr_i && !busy_o && buf_any) |=> busy_o);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == WR_CYCLES));

  // R7
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_req_i && !busy_o && !sel_wr_i && !stop_i));

  // R5
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy_o);
endmodule

bind pw_page_engine pw_page_engine_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_wr_i   (sel_wr_i),
  .stop_i     (stop_i),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .busy_o     (busy_o),
  .ram_we     (ram_we),
  .buf_any    (buf_any)
);

// File: tb/pw_page_engine_tb.sv
module pw_page_engine_tb;
  localparam int WR = 24;

  logic       clk, rst_n;
  logic       sel_wr_i, byte_vld_i, stop_i, rd_req_i;
  logic [7:0] byte_i;
  logic       rd_valid_o, busy_o;
  logic [7:0] rd_data_o;

  pw_page_engine #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr_i(sel_wr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .stop_i(stop_i), .rd_req_i(rd_req_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] shadow [256];
  logic [7:0] mptr;
  int busy_cnt;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every read result
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read", int'(rd_data_o), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o === e, t, int'(rd_data_o), int'(e));
      end
    end
  end

  task automatic cyc(bit s, bit v, logic [7:0] b, bit p, bit r);
    @(negedge clk);
    if (busy_o) busy_cnt++;
    sel_wr_i = s; byte_vld_i = v; byte_i = b; stop_i = p; rd_req_i = r;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 0, 0);
  endtask

  task automatic wait_idle(string req);
    do idle(); while (busy_o);
    check(busy_cnt == WR, req, busy_cnt, WR);
  endtask

  task automatic rd(string req);
    exp_q.push_back(shadow[mptr]);
    tag_q.push_back(req);
    cyc(0, 0, 8'h00, 0, 1);
    mptr = mptr + 8'd1;
  endtask

  // write transaction up to stop; shadow updated on commit (R3 R4 R5)
  task automatic wr_body(logic [7:0] addr, int n, logic [7:0] seed);
    logic [7:0] pend [16];
    bit         got  [16];
    logic [7:0] p;
    for (int i = 0; i < 16; i++) got[i] = 0;
    p = addr;
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 1, addr, 0, 0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 13);
      cyc(0, 1, d, 0, 0);
      pend[p[3:0]] = d;
      got[p[3:0]]  = 1;
      p = {p[7:4], p[3:0] + 4'd1};
    end
    cyc(0, 0, 8'h00, 1, 0);
    busy_cnt = 0;
    for (int i = 0; i < 16; i++)
      if (got[i]) shadow[{addr[7:4], 4'(i)}] = pend[i];
    mptr = p;
  endtask

  task automatic rd_seq(logic [7:0] addr, int n, string req);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 1, addr, 0, 0);
    mptr = addr;
    for (int k = 0; k < n; k++) rd(req);
    cyc(0, 0, 8'h00, 1, 0);
    idle();
    idle();
  endtask

  initial begin
    sel_wr_i = 0; byte_vld_i = 0; byte_i = 0; stop_i = 0; rd_req_i = 0;
    mptr = 0;
    busy_cnt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!busy_o && !rd_valid_o, "R1", {busy_o, rd_valid_o}, 0);
    rst_n = 1;
    repeat (4) idle();
    check(!busy_o && !rd_valid_o, "R1", {busy_o, rd_valid_o}, 0);

    // single byte, random read back
    wr_body(8'h10, 1, 8'hA5);
    wait_idle("R6 busy length");
    rd_seq(8'h10, 1, "R2 random read");

    // full page then overrun write with wrap
    wr_body(8'h30, 16, 8'h20);
    wait_idle("R6 busy length");
    wr_body(8'h3D, 18, 8'h80);
    wait_idle("R6 busy length");
    check(mptr == 8'h3F, "R3 model pointer", int'(mptr), 8'h3F);
    rd("R9 current read after write");
    idle(); idle();
    rd_seq(8'h30, 16, "R4 R3 page wrap overwrite");

    // partial page keeps other bytes
    wr_body(8'h50, 16, 8'h01);
    wait_idle("R6 busy length");
    wr_body(8'h57, 2, 8'h41);
    wait_idle("R6 busy length");
    rd_seq(8'h50, 16, "R5 partial page");

    // full-space wrap on sequential read
    wr_body(8'hF0, 16, 8'hC0);
    wait_idle("R6 busy length");
    wr_body(8'h00, 16, 8'h60);
    wait_idle("R6 busy length");
    rd_seq(8'hFE, 4, "R8 wrap 0xFF to 0x00");
    rd("R8 current read continues");
    idle(); idle();

    // uncommitted data discarded by new select; empty stop no busy
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h10, 0, 0);
    cyc(0, 1, 8'h77, 0, 0);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h10, 0, 0);
    cyc(0, 0, 8'h00, 1, 0);
    busy_cnt = 0;
    repeat (3) idle();
    check(busy_cnt == 0, "R6 empty stop", busy_cnt, 0);
    mptr = 8'h10;
    rd("R5 discarded bytes");
    idle(); idle();

    // priority: sel_wr with stop in same cycle opens write, no commit
    cyc(1, 0, 8'h00, 1, 1);
    busy_cnt = 0;
    idle(); idle();
    check(busy_cnt == 0, "R10 select wins", busy_cnt, 0);
    cyc(0, 0, 8'h00, 1, 0);
    // byte outside write select is dropped
    cyc(0, 1, 8'h99, 0, 0);
    cyc(0, 1, 8'h98, 0, 0);
    cyc(0, 0, 8'h00, 1, 0);
    busy_cnt = 0;
    idle(); idle();
    check(busy_cnt == 0, "R10 stray bytes dropped", busy_cnt, 0);
    rd("R10 pointer kept");
    idle(); idle();

    // inputs ignored while busy
    wr_body(8'h35, 1, 8'h5A);
    cyc(1, 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h10, 0, 0);
    cyc(0, 1, 8'hEE, 0, 0);
    cyc(0, 0, 8'h00, 1, 0);
    cyc(0, 0, 8'h00, 0, 1);
    cyc(0, 0, 8'h00, 0, 1);
    wait_idle("R7 busy not restarted");
    check(mptr == 8'h36, "R9 model pointer", int'(mptr), 8'h36);
    rd("R7 pointer unchanged");
    idle(); idle();
    rd_seq(8'h10, 1, "R7 memory unchanged");
    rd_seq(8'h35, 1, "R5 commit byte");

    repeat (4) idle();
    check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule